// File: doc/BRIEF.md
# Multi-Line Serial Deserializer

This block gathers single-bit input lines into parallel words. Up to two independent serial streams can run, and each stream samples 1, 2, 4 or 8 lines. A 4-bit selector for every line chooses its source. The source can be one of twelve data pins, the horizontal sync input, the vertical sync input, or a constant zero. On each cycle with the sample enable high, every active line shifts in one bit. Words are 1 to 16 bits wide and are assembled with the most significant or the least significant bit first. All lines of a stream finish their words on the same sample. Each finished word then appears for one cycle in that line's slot of a wide valid/data output, so the slot position gives the stream and line index.

A frame-start pulse realigns the word boundaries. A programmable words-per-frame count limits how many words each line produces between two frame starts. There is also a parallel mode, in which the deserializer is bypassed. In that mode every sample passes the twelve data pins through as one word, with an optional index that gives the sample's position in the frame. The configuration inputs are expected to stay steady within a frame. A frame start is issued after any change to them.

Top module: `line_deser`

## Requirements
- R1: With `cfgSerial`=0, each sample emits `{4'b0, dataPins}` in slot 0, with `wordValid[0]` high in the cycle after the sample. Slots 1 to 15 stay low.
- R2: In parallel mode with `cfgParIdx`=1, `parIdxOut` carries the 0-based count of samples emitted since the last frame start, alongside `wordValid[0]`. With `cfgParIdx`=0, `parIdxOut` stays 0.
- R3: The selector for stream s, line l sits at `cfgLineSel[(s*8+l)*4 +: 4]`. Codes 0x0 to 0xB pick `dataPins[code]`, 0xC picks `hsyncIn`, 0xD picks `vsyncIn`, and 0xE and 0xF give a constant 0.
- R4: `cfgLinesCode` 0/1/2/3 activates 1/2/4/8 lines per stream, starting at line 0. The word of stream s, line l appears in slot s*8+l, at `wordData[slot*16 +: 16]`. Inactive lines never raise their valid.
- R5: Stream 1 (slots 8 to 15) produces words only when `cfgTwoStreams`=1. Stream 0 runs whenever `cfgSerial`=1.
- R6: A word holds `cfgWordBitsM1`+1 bits, so 0x0 gives 1-bit words and 0xF gives 16-bit words. The valid rises in the cycle after the sample that carries the last bit, for all active lines of the stream at once. Unused upper bits are 0.
- R7: With `cfgLsbFirst`=0, the first bit sampled lands in bit W-1 of the word. With `cfgLsbFirst`=1, it lands in bit 0. W is the word width.
- R8: `frameStart` clears the bit and word counters. A sample taken in the same cycle is the first bit of a new word.
- R9: When `cfgFrameLen` is non-zero, each line emits at most that many words per frame (in parallel mode, at most that many samples). Further samples are ignored until the next frame start. A value of 0 removes the limit.
- R10: While `rstN` is low, `wordValid` and `parIdxOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgSerial | input | 1 | 1 = serial deserializing, 0 = parallel pass-through |
| cfgParIdx | input | 1 | Enables the sample index in parallel mode |
| cfgTwoStreams | input | 1 | Enables stream 1 |
| cfgLsbFirst | input | 1 | Bit order: 1 = first bit lands in bit 0 |
| cfgWordBitsM1 | input | 4 | Bits per word minus one |
| cfgLinesCode | input | 2 | Lines per stream code (1/2/4/8) |
| cfgFrameLen | input | 16 | Words per line (serial) or samples (parallel) per frame; 0 = unlimited |
| cfgLineSel | input | 64 | Sixteen 4-bit line source selectors |
| dataPins | input | 12 | Data input pins |
| hsyncIn | input | 1 | Horizontal sync input |
| vsyncIn | input | 1 | Vertical sync input |
| sampleEn | input | 1 | Takes one bit on every active line |
| frameStart | input | 1 | Realigns the counters to a new frame |
| wordValid | output | 16 | One valid per stream/line slot |
| wordData | output | 256 | Sixteen 16-bit word slots |
| parIdxOut | output | 16 | Sample index in parallel mode |

## Verification
The hardest case to reach from the ports is a frame start that lands partway through a word. This is sharpest when it arrives in the same cycle as a sample, while both streams are near their per-frame word limit. There the counters must restart without losing or doubling the coinciding bit. The stimulus gets there with sample-enable patterns that contain random gaps, so word boundaries drift against cycle counts. It also pulses frame start both with and without a sample a few bits into a word. Small frame limits are used so the limit is hit and then released within a short run.

// File: rtl/deser_pkg.sv
package deser_pkg;
  localparam int SEL_W     = 4;
  localparam int PIN_COUNT = 12;
  localparam int WORD_W    = 16;
  localparam int POS_W     = $clog2(WORD_W);
  localparam int CNT_W     = 16;

  typedef enum logic [SEL_W-1:0] {
    SRC_HSYNC = 4'hC,
    SRC_VSYNC = 4'hD,
    SRC_RSVD  = 4'hE,
    SRC_ZERO  = 4'hF
  } srcCode_e;

  // per-stream strobes from control to datapath
  typedef struct packed {
    logic             shiftEn;
    logic             lastBit;
    logic [POS_W-1:0] bitPos;
  } laneStrobe_t;

  // parallel-mode strobe
  typedef struct packed {
    logic             parEn;
    logic [CNT_W-1:0] parIdx;
  } parStrobe_t;
endpackage

// File: rtl/deser_src_mux.sv
module deser_src_mux
  import deser_pkg::*;
(
  input  logic [SEL_W-1:0]     sel,
  input  logic [PIN_COUNT-1:0] dataPins,
  input  logic                 hsyncIn,
  input  logic                 vsyncIn,
  output logic                 bitOut
);
  always_comb begin
    bitOut = 1'b0;
    case (sel)
      SRC_HSYNC: bitOut = hsyncIn;
      SRC_VSYNC: bitOut = vsyncIn;
      SRC_RSVD:  bitOut = 1'b0;
      SRC_ZERO:  bitOut = 1'b0;
      default: begin
        if (sel < SEL_W'(PIN_COUNT)) bitOut = dataPins[sel];
      end
    endcase
  end
endmodule

// File: rtl/deser_ctrl.sv
module deser_ctrl
  import deser_pkg::*;
#(
  parameter int STREAMS = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgSerial,
  input  logic                      cfgTwoStreams,
  input  logic [POS_W-1:0]          cfgWordBitsM1,
  input  logic [CNT_W-1:0]          cfgFrameLen,
  input  logic                      sampleEn,
  input  logic                      frameStart,
  output laneStrobe_t [STREAMS-1:0] strbOut,
  output parStrobe_t                pStrbOut
);
  logic unlimited;
  assign unlimited = (cfgFrameLen == '0);

  for (genvar s = 0; s < STREAMS; s++) begin : g_stream
    logic [POS_W-1:0] bitCnt, effBit;
    logic [CNT_W-1:0] wordCnt, effWord;
    logic             streamOn, room, go, isLast;

    assign streamOn = cfgSerial && ((s == 0) || cfgTwoStreams);
    assign effBit   = frameStart ? '0 : bitCnt;
    assign effWord  = frameStart ? '0 : wordCnt;
    assign room     = unlimited || (effWord < cfgFrameLen);
    assign go       = sampleEn && streamOn && room;
    assign isLast   = (effBit == cfgWordBitsM1);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bitCnt  <= '0;
        wordCnt <= '0;
      end else if (go) begin
        bitCnt  <= isLast ? '0 : effBit + POS_W'(1);
        wordCnt <= isLast ? effWord + CNT_W'(1) : effWord;
      end else if (frameStart) begin
        bitCnt  <= '0;
        wordCnt <= '0;
      end
    end

    assign strbOut[s].shiftEn = go;
    assign strbOut[s].lastBit = isLast;
    assign strbOut[s].bitPos  = effBit;

    AST_FRAME_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (frameStart && !sampleEn) |=> (bitCnt == '0 && wordCnt == '0)); // R8
    AST_WORD_WRAP: assert property (@(posedge clk) disable iff (!rstN)
      (go && isLast) |=> (bitCnt == '0)); // R6
  end

  logic [CNT_W-1:0] parCnt, effPar;
  logic             parGo;
  assign effPar = frameStart ? '0 : parCnt;
  assign parGo  = sampleEn && !cfgSerial && (unlimited || (effPar < cfgFrameLen));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           parCnt <= '0;
    else if (parGo)      parCnt <= effPar + CNT_W'(1);
    else if (frameStart) parCnt <= '0;
  end

  assign pStrbOut.parEn  = parGo;
  assign pStrbOut.parIdx = effPar;
endmodule

// File: rtl/deser_datapath.sv
module deser_datapath
  import deser_pkg::*;
#(
  parameter int STREAMS = 2,
  parameter int LINES   = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cfgParIdx,
  input  logic                           cfgTwoStreams,
  input  logic                           cfgLsbFirst,
  input  logic [1:0]                     cfgLinesCode,
  input  logic [STREAMS*LINES*SEL_W-1:0] cfgLineSel,
  input  logic [PIN_COUNT-1:0]           dataPins,
  input  logic                           hsyncIn,
  input  logic                           vsyncIn,
  input  laneStrobe_t [STREAMS-1:0]      strb,
  input  parStrobe_t                     pStrb,
  output logic [STREAMS*LINES-1:0]       wordValid,
  output logic [STREAMS*LINES*WORD_W-1:0] wordData,
  output logic [CNT_W-1:0]               parIdxOut
);
  localparam int SLOTS = STREAMS * LINES;

  logic [LINES-1:0] laneMask;
  always_comb begin
    for (int i = 0; i < LINES; i++) laneMask[i] = (i < (1 << cfgLinesCode));
  end

  for (genvar s = 0; s < STREAMS; s++) begin : g_stream
    for (genvar l = 0; l < LINES; l++) begin : g_line
      localparam int SLOT = s * LINES + l;
      logic              srcBit, hit;
      logic [WORD_W-1:0] shReg, base, nextWord, dReg;
      logic              vReg;

      deser_src_mux u_mux (
        .sel     (cfgLineSel[SLOT*SEL_W +: SEL_W]),
        .dataPins(dataPins),
        .hsyncIn (hsyncIn),
        .vsyncIn (vsyncIn),
        .bitOut  (srcBit)
      );

      assign hit      = strb[s].shiftEn && laneMask[l];
      assign base     = (strb[s].bitPos == '0) ? '0 : shReg;
      assign nextWord = cfgLsbFirst ? (base | (WORD_W'(srcBit) << strb[s].bitPos))
                                    : {base[WORD_W-2:0], srcBit};

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)    shReg <= '0;
        else if (hit) shReg <= nextWord;
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          vReg <= 1'b0;
          dReg <= '0;
        end else begin
          vReg <= (hit && strb[s].lastBit) || ((SLOT == 0) && pStrb.parEn);
          if (hit && strb[s].lastBit)            dReg <= nextWord;
          else if ((SLOT == 0) && pStrb.parEn)   dReg <= WORD_W'(dataPins);
        end
      end

      assign wordValid[SLOT]                   = vReg;
      assign wordData[SLOT*WORD_W +: WORD_W]   = dReg;
    end

    AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      strb[s].shiftEn |=> ((wordValid[s*LINES +: LINES] & ~$past(laneMask)) == '0)); // R4
    AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
      (wordValid[s*LINES +: LINES] != '0) |-> wordValid[s*LINES]); // R6
  end

  if (STREAMS > 1) begin : g_second
    AST_SECOND_OFF: assert property (@(posedge clk) disable iff (!rstN)
      !cfgTwoStreams |=> (wordValid[SLOTS-1:LINES] == '0)); // R5
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) parIdxOut <= '0;
    else       parIdxOut <= (pStrb.parEn && cfgParIdx) ? pStrb.parIdx : '0;
  end

  AST_PAR_SLOT0: assert property (@(posedge clk) disable iff (!rstN)
    pStrb.parEn |=> (wordValid == SLOTS'(1))); // R1
endmodule

// File: rtl/line_deser.sv
module line_deser
  import deser_pkg::*;
#(
  parameter int STREAMS = 2,
  parameter int LINES   = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cfgSerial,
  input  logic                            cfgParIdx,
  input  logic                            cfgTwoStreams,
  input  logic                            cfgLsbFirst,
  input  logic [POS_W-1:0]                cfgWordBitsM1,
  input  logic [1:0]                      cfgLinesCode,
  input  logic [CNT_W-1:0]                cfgFrameLen,
  input  logic [STREAMS*LINES*SEL_W-1:0]  cfgLineSel,
  input  logic [PIN_COUNT-1:0]            dataPins,
  input  logic                            hsyncIn,
  input  logic                            vsyncIn,
  input  logic                            sampleEn,
  input  logic                            frameStart,
  output logic [STREAMS*LINES-1:0]        wordValid,
  output logic [STREAMS*LINES*WORD_W-1:0] wordData,
  output logic [CNT_W-1:0]                parIdxOut
);
  laneStrobe_t [STREAMS-1:0] strb;
  parStrobe_t                pStrb;

  deser_ctrl #(.STREAMS(STREAMS)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgSerial    (cfgSerial),
    .cfgTwoStreams(cfgTwoStreams),
    .cfgWordBitsM1(cfgWordBitsM1),
    .cfgFrameLen  (cfgFrameLen),
    .sampleEn     (sampleEn),
    .frameStart   (frameStart),
    .strbOut      (strb),
    .pStrbOut     (pStrb)
  );

  deser_datapath #(.STREAMS(STREAMS), .LINES(LINES)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cfgParIdx    (cfgParIdx),
    .cfgTwoStreams(cfgTwoStreams),
    .cfgLsbFirst  (cfgLsbFirst),
    .cfgLinesCode (cfgLinesCode),
    .cfgLineSel   (cfgLineSel),
    .dataPins     (dataPins),
    .hsyncIn      (hsyncIn),
    .vsyncIn      (vsyncIn),
    .strb         (strb),
    .pStrb        (pStrb),
    .wordValid    (wordValid),
    .wordData     (wordData),
    .parIdxOut    (parIdxOut)
  );
endmodule

// File: tb/sim_line_deser.sv
`timescale 1ns/1ps
module sim_line_deser;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, cfgSerial, cfgParIdx, cfgTwoStreams, cfgLsbFirst;
  logic [3:0]  cfgWordBitsM1;
  logic [1:0]  cfgLinesCode;
  logic [15:0] cfgFrameLen;
  logic [63:0] cfgLineSel;
  logic [11:0] dataPins;
  logic        hsyncIn, vsyncIn, sampleEn, frameStart;
  logic [15:0] wordValid;
  logic [255:0] wordData;
  logic [15:0] parIdxOut;

  line_deser u0 (.*);

  int nCmp = 0, nBad = 0;
  string curReq = "R10";

  // behavioural reference
  logic [7:0]  qA[$];
  logic [7:0]  qB[$];
  int          wcA, wcB, pc;
  logic [15:0] expValid = '0;
  logic [15:0] expData [16];
  logic [15:0] expIdx = '0;

  function automatic logic pinOf(input int s, input int l);
    logic [3:0] sel;
    sel = cfgLineSel[(s*8+l)*4 +: 4];
    if (sel < 12) return dataPins[sel];
    if (sel == 12) return hsyncIn;
    if (sel == 13) return vsyncIn;
    return 1'b0;
  endfunction

  task automatic streamStep(input int s);
    logic [7:0]  smp;
    logic [15:0] w;
    logic        b;
    int n, wdt, nl;
    wdt = int'(cfgWordBitsM1) + 1;
    nl  = 1 << cfgLinesCode;
    smp = '0;
    for (int l = 0; l < 8; l++) smp[l] = pinOf(s, l);
    if (s == 0) begin qA.push_back(smp); n = qA.size(); end
    else        begin qB.push_back(smp); n = qB.size(); end
    if (n == wdt) begin
      for (int l = 0; l < nl; l++) begin
        w = '0;
        for (int i = 0; i < wdt; i++) begin
          b = (s == 0) ? qA[i][l] : qB[i][l];
          if (cfgLsbFirst) w[i] = b;
          else             w = {w[14:0], b};
        end
        expValid[s*8+l] = 1'b1;
        expData[s*8+l]  = w;
      end
      if (s == 0) begin qA.delete(); wcA++; end
      else        begin qB.delete(); wcB++; end
    end
  endtask

  task automatic modelStep();
    expValid = '0;
    expIdx   = '0;
    if (!rstN || frameStart) begin
      qA.delete(); qB.delete(); wcA = 0; wcB = 0; pc = 0;
    end
    if (rstN && sampleEn) begin
      if (!cfgSerial) begin
        if (cfgFrameLen == 0 || pc < int'(cfgFrameLen)) begin
          expValid[0] = 1'b1;
          expData[0]  = {4'b0, dataPins};
          if (cfgParIdx) expIdx = 16'(pc);
          pc++;
        end
      end else begin
        if (cfgFrameLen == 0 || wcA < int'(cfgFrameLen)) streamStep(0);
        if (cfgTwoStreams && (cfgFrameLen == 0 || wcB < int'(cfgFrameLen))) streamStep(1);
      end
    end
  endtask

  always @(posedge clk) modelStep();

  task automatic checkOut();
    bit bad;
    int badSlot;
    bad = 0; badSlot = -1;
    nCmp++;
    if (wordValid !== expValid || parIdxOut !== expIdx) bad = 1;
    for (int i = 0; i < 16; i++)
      if (expValid[i] && wordData[i*16 +: 16] !== expData[i]) begin bad = 1; badSlot = i; end
    if (bad) begin
      nBad++;
      if (badSlot >= 0)
        $display("FAIL %s t=%0t slot %0d data got %h expected %h (valid got %h expected %h)",
                 curReq, $time, badSlot, wordData[badSlot*16 +: 16], expData[badSlot], wordValid, expValid);
      else
        $display("FAIL %s t=%0t valid got %h expected %h, idx got %0d expected %0d",
                 curReq, $time, wordValid, expValid, parIdxOut, expIdx);
    end
  endtask

  task automatic cyc(input logic en, input logic fs);
    @(negedge clk);
    checkOut();
    sampleEn   = en;
    frameStart = fs;
    dataPins   = 12'($urandom);
    hsyncIn    = 1'($urandom);
    vsyncIn    = 1'($urandom);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(($urandom % 4) != 0, 1'b0);
  endtask

  task automatic setup(input logic ser, input logic pidx, input logic two, input logic lsb,
                       input logic [3:0] bm1, input logic [1:0] lc, input logic [15:0] fl,
                       input logic [63:0] sel);
    cyc(1'b0, 1'b0);
    cfgSerial = ser; cfgParIdx = pidx; cfgTwoStreams = two; cfgLsbFirst = lsb;
    cfgWordBitsM1 = bm1; cfgLinesCode = lc; cfgFrameLen = fl; cfgLineSel = sel;
    cyc(1'b0, 1'b1);
  endtask

  initial begin
    rstN = 1'b0; cfgSerial = 0; cfgParIdx = 0; cfgTwoStreams = 0; cfgLsbFirst = 0;
    cfgWordBitsM1 = 0; cfgLinesCode = 0; cfgFrameLen = 0; cfgLineSel = '0;
    dataPins = '0; hsyncIn = 0; vsyncIn = 0; sampleEn = 0; frameStart = 0;
    @(posedge clk);
    curReq = "R10";
    sampleEn = 1'b1;
    for (int i = 0; i < 3; i++) begin @(negedge clk); checkOut(); end
    rstN = 1'b1; sampleEn = 1'b0;

    curReq = "R1";  setup(0, 0, 0, 0, 4'h0, 2'd0, 16'd0, 64'h0); run(30);
    curReq = "R2";  setup(0, 1, 0, 0, 4'h0, 2'd0, 16'd0, 64'h0); run(25);
    curReq = "R9";  setup(0, 1, 0, 0, 4'h0, 2'd0, 16'd6, 64'h0); run(20);
    cyc(1'b1, 1'b1); run(15);
    curReq = "R6";  setup(1, 0, 0, 0, 4'h7, 2'd0, 16'd0, 64'h0); run(60);
    curReq = "R7";  setup(1, 0, 0, 1, 4'h7, 2'd0, 16'd0, 64'h0); run(60);
    curReq = "R3";  setup(1, 0, 1, 0, 4'h2, 2'd3, 16'd0, 64'h76543210_FEDCBA98); run(80);
    setup(1, 0, 1, 1, 4'h5, 2'd3, 16'd0, 64'hDCCBA987_FFEEDDCC); run(60);
    curReq = "R4";  setup(1, 0, 1, 0, 4'h3, 2'd1, 16'd0, 64'h01234567_89AB0123); run(50);
    setup(1, 0, 1, 1, 4'h3, 2'd2, 16'd0, 64'h01234567_89AB0123); run(50);
    curReq = "R6";  setup(1, 0, 1, 0, 4'h0, 2'd2, 16'd0, 64'h3210BA98_76543210); run(30);
    setup(1, 0, 1, 0, 4'hF, 2'd2, 16'd0, 64'h3210BA98_76543210); run(120);
    setup(1, 0, 1, 1, 4'hF, 2'd3, 16'd0, 64'hBA987654_76543210); run(100);
    curReq = "R8";  setup(1, 0, 1, 0, 4'h6, 2'd1, 16'd0, 64'h00000021_00000043);
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < 3 + k; j++) cyc(1'b1, 1'b0);
      cyc((k % 2) == 0, 1'b1);
    end
    run(40);
    curReq = "R9";  setup(1, 0, 1, 0, 4'h1, 2'd2, 16'd3, 64'h0123BA98_76543210); run(40);
    cyc(1'b1, 1'b1); run(30);
    cyc(1'b0, 1'b1); run(30);
    curReq = "R5";  setup(1, 0, 0, 1, 4'h3, 2'd3, 16'd0, 64'h76543210_BA987654); run(50);
    cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL %s watchdog expired: got still running, expected finished", curReq);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule